// File: doc/BRIEF.md
# BCD Digit Latch and Seven-Segment LCD Driver

This block takes a four-bit binary-coded decimal digit and stores it in a hold register. It turns the stored digit into the seven segment lines of a numeric display. A load-enable input sets whether the stored digit follows the data inputs or keeps its value. While load is enabled, the data is sampled on every rising clock edge, and the outputs show the new digit in the cycle after that edge.

The display goes blank in two cases: when a blanking request is raised, or when the stored value is not a decimal digit (ten to fifteen). Blanking acts after the hold register, so the stored digit is kept. A phase input inverts all seven outputs. If the same square wave drives the phase input and the display backplane, the liquid-crystal segments see an AC drive with no DC component.

Top module: `bcd_seg_lcd_drv`

## Requirements
- R1: While reset is asserted, and until the first load after it, the stored code is 0. With blanking and phase low, `seg_o` is then 7'h3F.
- R2: With `load_en` high at a rising clock edge, the stored code takes the value of `bcd_in`. From the following cycle, `seg_o` shows that code.
- R3: With `load_en` low at a rising clock edge, the stored code keeps its value. Changes on `bcd_in` do not reach `seg_o`.
- R4: With `blank_req` high and `phase` low, `seg_o` is 7'h00, whatever the stored code.
- R5: A stored code from 10 to 15 blanks the display: 7'h00 with `phase` low.
- R6: With `phase` high, `seg_o` is the bitwise inverse of the value it would have with `phase` low. This includes blanking, which then gives 7'h7F.
- R7: With `phase` low, a lit segment is 1. Bit 0 is segment a and bit 6 is segment g, in the order a, b, c, d, e, f, g. The digits give these values: 0 gives 7'h3F, 1 gives 7'h06, 2 gives 7'h5B, 3 gives 7'h4F, 4 gives 7'h66, 5 gives 7'h6D and 8 gives 7'h7F.
- R8: Digit 6 includes the top segment and gives 7'h7D. Digit 7 lights only a, b and c and gives 7'h07. Digit 9 includes the bottom segment and gives 7'h6F.
- R9: A digit stored before or during blanking appears again once `blank_req` returns low, even if no load takes place in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the data inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bcd_in | input | 4 | BCD digit, bit 0 is the least significant |
| load_en | input | 1 | High: sample `bcd_in` on each clock. Low: hold the stored code |
| blank_req | input | 1 | High forces every segment inactive |
| phase | input | 1 | High inverts all segment outputs |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g |

## Verification
Four properties are checked on every cycle. A stored code follows the input when loaded (R2). Blanking gives all-zero or all-one outputs depending on phase (R4, R6). Codes above nine never reach a lit pattern (R5). With load disabled and the controls steady, the outputs stay constant (R3).

The properties cannot confirm the exact lit pattern of each digit. Only the bench's scenarios show that: the patterns of R7 and R8, the reset value, and the return of a held digit after blanking (R9).

// File: rtl/bcdseg_pkg.sv
package bcdseg_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SEG_N   = 7;
  localparam int unsigned MAX_DIG = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  // Segment order: bit 0 = a ... bit 6 = g, active high
  function automatic seg_t digit_pattern(input code_t d);
    seg_t p;
    unique case (d)
      4'd0:    p = 7'h3F;
      4'd1:    p = 7'h06;
      4'd2:    p = 7'h5B;
      4'd3:    p = 7'h4F;
      4'd4:    p = 7'h66;
      4'd5:    p = 7'h6D;
      4'd6:    p = 7'h7D;
      4'd7:    p = 7'h07;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h6F;
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bcdseg_rst_sync.sv
module bcdseg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/bcdseg_code_hold.sv
module bcdseg_code_hold
  import bcdseg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ok,
  input  logic  load_en,
  input  code_t code_in,
  output code_t code_q
);
  code_t code_d;

  always_comb begin
    code_d = code_q;
    if (load_en) code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) code_q <= '0;
    else         code_q <= code_d;
  end
endmodule

// File: rtl/bcdseg_decode.sv
module bcdseg_decode
  import bcdseg_pkg::*;
(
  input  code_t code_q,
  input  logic  blank_req,
  output seg_t  seg_lit
);
  logic illegal;

  always_comb begin
    illegal = (code_q > code_t'(MAX_DIG));
    seg_lit = (blank_req || illegal) ? '0 : digit_pattern(code_q);
  end
endmodule

// File: rtl/bcdseg_polarity.sv
module bcdseg_polarity #(
  parameter int unsigned N = 7
) (
  input  logic         phase,
  input  logic [N-1:0] seg_lit,
  output logic [N-1:0] seg_drv
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign seg_drv[i] = seg_lit[i] ^ phase;
  end
endmodule

// File: rtl/bcd_seg_lcd_drv.sv
module bcd_seg_lcd_drv
  import bcdseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] bcd_in,
  input  logic              load_en,
  input  logic              blank_req,
  input  logic              phase,
  output logic [SEG_N-1:0]  seg_o
);
  localparam int unsigned RST_STAGES = 2;

  logic  rst_ok;
  code_t code_q;
  seg_t  seg_lit;

  bcdseg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  bcdseg_code_hold u_hold (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .load_en (load_en),
    .code_in (bcd_in),
    .code_q  (code_q)
  );

  bcdseg_decode u_dec (
    .code_q    (code_q),
    .blank_req (blank_req),
    .seg_lit   (seg_lit)
  );

  bcdseg_polarity #(.N(SEG_N)) u_pol (
    .phase   (phase),
    .seg_lit (seg_lit),
    .seg_drv (seg_o)
  );
endmodule

// File: rtl/bcd_seg_lcd_drv_chk.sv
module bcd_seg_lcd_drv_chk
  import bcdseg_pkg::*;
(
  input logic  clk,
  input logic  rst_ok,
  input code_t bcd_in,
  input logic  load_en,
  input logic  blank_req,
  input logic  phase,
  input code_t code_q,
  input seg_t  seg_o
);
  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    load_en |=> (code_q == $past(bcd_in)));

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !load_en |=> (!($stable(blank_req) && $stable(phase)) || $stable(seg_o)));

  // R4
  blank_low_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (blank_req && !phase) |-> (seg_o == '0));

  // R6
  blank_high_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (blank_req && phase) |-> (seg_o == '1));

  // R5
  illegal_blank_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (code_q > code_t'(MAX_DIG)) |-> (seg_o == (phase ? '1 : '0)));
endmodule

bind bcd_seg_lcd_drv bcd_seg_lcd_drv_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .bcd_in    (bcd_in),
  .load_en   (load_en),
  .blank_req (blank_req),
  .phase     (phase),
  .code_q    (code_q),
  .seg_o     (seg_o)
);

// File: tb/test_bcd_seg_lcd_drv.sv
module test_bcd_seg_lcd_drv;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [6:0] exp;
    string      req;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bcd_in;
  logic       load_en, blank_req, phase;
  logic [6:0] seg_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [3:0] m_held = 4'd0;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_seg_lcd_drv i_bcd_seg_lcd_drv (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .load_en(load_en),
    .blank_req(blank_req), .phase(phase), .seg_o(seg_o)
  );

  function automatic logic [6:0] ref_pat(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;
      4'd2: return 7'h5B;  4'd3: return 7'h4F;
      4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;
      4'd8: return 7'h7F;  4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: seg_o=%h expected %h", req, act, exp);
    end
  endtask

  // driver: one cycle per call, expected value pushed to the scoreboard
  task automatic apply(input logic [3:0] code, input logic ld, input logic bl,
                       input logic ph, input string req);
    sb_item_t it;
    logic [6:0] e;
    @(negedge clk);
    bcd_in = code; load_en = ld; blank_req = bl; phase = ph;
    if (ld) m_held = code;
    e = (bl || m_held > 4'd9) ? 7'h00 : ref_pat(m_held);
    if (ph) e = ~e;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(seg_o, it.exp, it.req);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: seg_o=%h expected completion", seg_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bcd_in = 4'd8; load_en = 1'b1; blank_req = 1'b0; phase = 1'b0;
    repeat (3) @(negedge clk);
    check(seg_o, 7'h3F, "R1 during reset");
    rst_n = 1'b1;
    load_en = 1'b0;
    repeat (4) @(negedge clk);
    check(seg_o, 7'h3F, "R1 after reset release");

    // R2 R7 R8 R5: every code, phase low
    for (int d = 0; d < 16; d++) begin
      apply(4'(d), 1'b1, 1'b0, 1'b0,
            d > 9 ? "R5 illegal code" :
            (d == 6 || d == 7 || d == 9) ? "R8 digit pattern" : "R7 R2 digit pattern");
    end
    // R6: inverted digits and inverted illegal code
    for (int d = 0; d < 10; d++) apply(4'(d), 1'b1, 1'b0, 1'b1, "R6 inverted digit");
    apply(4'd12, 1'b1, 1'b0, 1'b1, "R6 R5 inverted illegal");

    // R3: hold
    apply(4'd3, 1'b1, 1'b0, 1'b0, "R2 load 3");
    apply(4'd8, 1'b0, 1'b0, 1'b0, "R3 hold ignores 8");
    apply(4'd5, 1'b0, 1'b0, 1'b0, "R3 hold ignores 5");

    // R4 R6 R9: blanking over a kept digit
    apply(4'd7, 1'b1, 1'b1, 1'b0, "R4 blank while loading");
    apply(4'd2, 1'b0, 1'b1, 1'b1, "R6 blank inverted");
    apply(4'd2, 1'b0, 1'b0, 1'b0, "R9 digit returns after blank");
    apply(4'd9, 1'b1, 1'b1, 1'b0, "R4 blank");
    apply(4'd0, 1'b0, 1'b0, 1'b1, "R9 R6 kept digit inverted");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule